// File: doc/BRIEF.md
# Scalable Word-Serial Montgomery Multiplier

This block computes the fully reduced Montgomery product X·Y·2^-k mod M for k-bit operands, with k = W·E. Each operand is held as E words of W bits in an external synchronous-read word memory. The block reads the words through one shared word address. The multiplier X is captured once at the start. The multiplicand Y and the modulus M are streamed word by word into a chain of N identical processing elements (PEs). Each PE applies one multiplier bit to the partial sum as it flows past. Neighbouring stages run two cycles apart, so a stage has the low words it needs before it needs them.

When the chain is shorter than k, the words leaving the last stage are written to the result memory. They are then read back into the first stage for the next group of N multiplier bits. One extra top bit is kept in a register. After k/N passes, the block compares the partial sum with M word by word. It subtracts M in place only if the sum is at least M. `done` pulses when the last result word has been written.

The memories have a one-cycle read latency: data appears the cycle after the address. N must divide k.

Top module: `montMul`

## Requirements
- R1: After reset, `busy`, `done` and `resWe` are all low.
- R2: For an odd M and X, Y < M, the result memory words 0..E-1 hold X·Y·2^-k mod M when `done` pulses, with word j carrying bits j·W to j·W+W-1. The result is fully reduced, below M.
- R3: With X = 0, the stored result is zero.
- R4: `done` is high for exactly one cycle, and only while `busy` is high. `busy` rises in the cycle after `start` is sampled in idle, and falls in the cycle after `done`.
- R5: `busy` stays high for exactly E + (k/N)·(2N+E+1) + E + 3 cycles. Add E+1 more cycles when the final subtraction is needed.
- R6: The result does not depend on N: a chain of 2 stages and a chain of 4 stages give the same words.
- R7: A `start` pulse while `busy` is high has no effect: the result and the busy length are unchanged.
- R8: The result memory is written only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication (sampled in idle) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdAddr | output | $clog2(E) | Word address shared by all read ports |
| xRdata | input | W | Multiplier word read one cycle after the address |
| yRdata | input | W | Multiplicand word read one cycle after the address |
| mRdata | input | W | Modulus word read one cycle after the address |
| resRdata | input | W | Result-memory word read one cycle after the address |
| resWe | output | 1 | Result-memory write enable |
| resWaddr | output | $clog2(E) | Result-memory write address |
| resWdata | output | W | Result-memory write data |

## Verification
The assertions rely on the operands obeying the Montgomery preconditions: M odd, X and Y below M, and the memories unchanged while `busy` is high. The bound on the partial sum, and with it the single final subtraction, depends on these conditions. The stimulus draws odd moduli at random, including the all-ones modulus, and reduces the random X and Y modulo M before loading them. Memory contents are written only while both instances are idle. The only pulse sent during a run is the extra `start`, which checks that it is ignored.

// File: rtl/montPkg.sv
package montPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LDX, ST_PASS, ST_DRAIN, ST_CHK, ST_CHKW, ST_DEC, ST_SUB, ST_FIN, ST_DONE
  } stateT;

  // strobes, registered in control so that they line up with read data
  typedef struct packed {
    logic loadX;      // capture a multiplier word
    logic feed;       // stream a word into stage 0
    logic firstPass;  // partial sum is zero on the first pass
    logic shiftX;     // advance the multiplier by one pass
    logic subChk;     // compare partial sum with modulus
    logic subWr;      // write partial sum minus modulus
  } ctrlT;

endpackage

// File: rtl/montPe.sv
module montPe #(
  parameter int W = 16,
  parameter int E = 4,
  localparam int IW = (E > 1) ? $clog2(E) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inV,
  input  logic [IW-1:0] inIdx,
  input  logic [W-1:0]  inS,
  input  logic          inTop,
  input  logic [W-1:0]  inY,
  input  logic [W-1:0]  inM,
  input  logic          xBit,
  output logic          outV,
  output logic [IW-1:0] outIdx,
  output logic [W-1:0]  outS,
  output logic          outTop,
  output logic [W-1:0]  outY,
  output logic [W-1:0]  outM
);
  logic [1:0]   carryQ;
  logic [1:0]   hiQ;
  logic         qQ;
  logic         lastQ;
  logic [W-1:0] tQ, yQ, mQ;
  logic         firstWord, lastWord, qNow;
  logic [W+1:0] sum;
  logic [1:0]   hiNow;

  assign firstWord = (inIdx == '0);
  assign lastWord  = (inIdx == IW'(E - 1));
  assign qNow      = firstWord ? (inS[0] ^ (xBit & inY[0])) : qQ;

  always_comb begin
    sum = {2'b00, inS};
    if (xBit) sum = sum + {2'b00, inY};
    if (qNow) sum = sum + {2'b00, inM};
    if (!firstWord) sum = sum + {{W{1'b0}}, carryQ};
    hiNow = sum[W+1:W] + {1'b0, inTop};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryQ <= '0; hiQ <= '0; qQ <= 1'b0; lastQ <= 1'b0;
      tQ <= '0; yQ <= '0; mQ <= '0;
      outV <= 1'b0; outIdx <= '0; outS <= '0; outTop <= 1'b0; outY <= '0; outM <= '0;
    end else begin
      lastQ <= inV && lastWord;
      if (inV) begin
        tQ     <= sum[W-1:0];
        carryQ <= sum[W+1:W];
        qQ     <= qNow;
        yQ     <= inY;
        mQ     <= inM;
        if (lastWord) hiQ <= hiNow;
      end
      outV <= (inV && !firstWord) || lastQ;
      if (inV && !firstWord) begin
        outS   <= {sum[0], tQ[W-1:1]};
        outIdx <= inIdx - 1'b1;
        outTop <= 1'b0;
        outY   <= yQ;
        outM   <= mQ;
      end else if (lastQ) begin
        outS   <= {hiQ[0], tQ[W-1:1]};
        outIdx <= IW'(E - 1);
        outTop <= hiQ[1];
        outY   <= yQ;
        outM   <= mQ;
      end
    end
  end

  AST_WB_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    (outV && outIdx != '0) |-> ($past(outV) && outIdx == $past(outIdx) + 1'b1)); // R5

endmodule

// File: rtl/montDatapath.sv
module montDatapath import montPkg::*; #(
  parameter int W = 16,
  parameter int E = 4,
  parameter int N = 4,
  localparam int K  = W * E,
  localparam int IW = (E > 1) ? $clog2(E) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlT          strobe,
  input  logic [IW-1:0] dIdx,
  input  logic [W-1:0]  xRdata,
  input  logic [W-1:0]  yRdata,
  input  logic [W-1:0]  mRdata,
  input  logic [W-1:0]  resRdata,
  output logic          resWe,
  output logic [IW-1:0] resWaddr,
  output logic [W-1:0]  resWdata,
  output logic          wbLast,
  output logic          needSub
);
  logic [K-1:0]  xReg;
  logic          sTopQ, borrowQ;
  logic          chV   [N+1];
  logic [IW-1:0] chIdx [N+1];
  logic [W-1:0]  chS   [N+1];
  logic          chTop [N+1];
  logic [W-1:0]  chY   [N+1];
  logic [W-1:0]  chM   [N+1];
  logic [W:0]    diff;
  logic          bIn;

  assign chV[0]   = strobe.feed;
  assign chIdx[0] = dIdx;
  assign chS[0]   = strobe.firstPass ? '0 : resRdata;
  assign chTop[0] = strobe.firstPass ? 1'b0 : sTopQ;
  assign chY[0]   = yRdata;
  assign chM[0]   = mRdata;

  for (genvar s = 0; s < N; s++) begin : gStage
    montPe #(.W(W), .E(E)) uPe (
      .clk(clk), .rstN(rstN),
      .inV(chV[s]), .inIdx(chIdx[s]), .inS(chS[s]), .inTop(chTop[s]),
      .inY(chY[s]), .inM(chM[s]), .xBit(xReg[s]),
      .outV(chV[s+1]), .outIdx(chIdx[s+1]), .outS(chS[s+1]), .outTop(chTop[s+1]),
      .outY(chY[s+1]), .outM(chM[s+1])
    );
  end

  assign bIn  = (dIdx == '0) ? 1'b0 : borrowQ;
  assign diff = {1'b0, resRdata} - {1'b0, mRdata} - {{W{1'b0}}, bIn};

  assign wbLast   = chV[N] && (chIdx[N] == IW'(E - 1));
  assign needSub  = sTopQ || !borrowQ;
  assign resWe    = chV[N] || strobe.subWr;
  assign resWaddr = strobe.subWr ? dIdx : chIdx[N];
  assign resWdata = strobe.subWr ? diff[W-1:0] : chS[N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg <= '0; sTopQ <= 1'b0; borrowQ <= 1'b0;
    end else begin
      if (strobe.loadX) xReg[int'(dIdx)*W +: W] <= xRdata;
      else if (strobe.shiftX) xReg <= xReg >> N;
      if (wbLast) sTopQ <= chTop[N];
      if (strobe.subChk || strobe.subWr) borrowQ <= diff[W];
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    !(chV[N] && strobe.subWr)); // R8

endmodule

// File: rtl/montCtrl.sv
module montCtrl import montPkg::*; #(
  parameter int W = 16,
  parameter int E = 4,
  parameter int N = 4,
  localparam int K  = W * E,
  localparam int P  = K / N,
  localparam int IW = (E > 1) ? $clog2(E) : 1,
  localparam int PW = $clog2(P + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          wbLast,
  input  logic          needSub,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] rdAddr,
  output ctrlT          strobe,
  output logic [IW-1:0] dIdx
);
  stateT         st;
  logic [IW-1:0] cnt;
  logic [PW-1:0] passCnt;
  logic          firstQ;
  logic          cntEnd;
  ctrlT          nxt;

  assign cntEnd = (cnt == IW'(E - 1));
  assign rdAddr = cnt;
  assign busy   = (st != ST_IDLE);
  assign done   = (st == ST_DONE);

  always_comb begin
    nxt = '0;
    nxt.firstPass = firstQ;
    case (st)
      ST_LDX:   nxt.loadX  = 1'b1;
      ST_PASS:  nxt.feed   = 1'b1;
      ST_DRAIN: nxt.shiftX = wbLast;
      ST_CHK:   nxt.subChk = 1'b1;
      ST_SUB:   nxt.subWr  = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_IDLE; cnt <= '0; passCnt <= '0; firstQ <= 1'b0;
      strobe <= '0; dIdx <= '0;
    end else begin
      strobe <= nxt;
      dIdx   <= cnt;
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_LDX; cnt <= '0; passCnt <= '0; firstQ <= 1'b1;
        end
        ST_LDX: begin
          cnt <= cnt + 1'b1;
          if (cntEnd) begin cnt <= '0; st <= ST_PASS; end
        end
        ST_PASS: begin
          cnt <= cnt + 1'b1;
          if (cntEnd) begin cnt <= '0; st <= ST_DRAIN; end
        end
        ST_DRAIN: if (wbLast) begin
          firstQ  <= 1'b0;
          passCnt <= passCnt + 1'b1;
          st      <= (passCnt == PW'(P - 1)) ? ST_CHK : ST_PASS;
        end
        ST_CHK: begin
          cnt <= cnt + 1'b1;
          if (cntEnd) begin cnt <= '0; st <= ST_CHKW; end
        end
        ST_CHKW: st <= ST_DEC;
        ST_DEC:  st <= needSub ? ST_SUB : ST_DONE;
        ST_SUB: begin
          cnt <= cnt + 1'b1;
          if (cntEnd) begin cnt <= '0; st <= ST_FIN; end
        end
        ST_FIN:  st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R4
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R4
  AST_PASS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CHK) |-> (passCnt == PW'(P))); // R5

endmodule

// File: rtl/montMul.sv
module montMul import montPkg::*; #(
  parameter int W = 16,
  parameter int E = 4,
  parameter int N = 4,
  localparam int IW = (E > 1) ? $clog2(E) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] rdAddr,
  input  logic [W-1:0]  xRdata,
  input  logic [W-1:0]  yRdata,
  input  logic [W-1:0]  mRdata,
  input  logic [W-1:0]  resRdata,
  output logic          resWe,
  output logic [IW-1:0] resWaddr,
  output logic [W-1:0]  resWdata
);
  ctrlT          strobe;
  logic [IW-1:0] dIdx;
  logic          wbLast, needSub;

  initial begin
    assert ((W * E) % N == 0 && W >= 2 && E >= 2)
      else $error("stage count must divide the operand length");
  end

  montCtrl #(.W(W), .E(E), .N(N)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .wbLast(wbLast), .needSub(needSub),
    .busy(busy), .done(done), .rdAddr(rdAddr), .strobe(strobe), .dIdx(dIdx)
  );

  montDatapath #(.W(W), .E(E), .N(N)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dIdx(dIdx),
    .xRdata(xRdata), .yRdata(yRdata), .mRdata(mRdata), .resRdata(resRdata),
    .resWe(resWe), .resWaddr(resWaddr), .resWdata(resWdata),
    .wbLast(wbLast), .needSub(needSub)
  );

  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    resWe |-> busy); // R8

endmodule

// File: tb/sim_montMul.sv
module sim_montMul;
  localparam int W  = 16;
  localparam int E  = 4;
  localparam int K  = W * E;
  localparam int NA = 4;
  localparam int NB = 2;
  localparam int IW = $clog2(E);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  always #2ns clk = ~clk;

  logic [W-1:0] xMem [E];
  logic [W-1:0] yMem [E];
  logic [W-1:0] mMem [E];
  logic [W-1:0] resA [E];
  logic [W-1:0] resB [E];

  logic busyA, doneA, weA, busyB, doneB, weB;
  logic [IW-1:0] raA, waA, raB, waB;
  logic [W-1:0] xdA, ydA, mdA, rdA, wdA, xdB, ydB, mdB, rdB, wdB;

  montMul #(.W(W), .E(E), .N(NA)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .busy(busyA), .done(doneA), .rdAddr(raA),
    .xRdata(xdA), .yRdata(ydA), .mRdata(mdA), .resRdata(rdA),
    .resWe(weA), .resWaddr(waA), .resWdata(wdA)
  );
  montMul #(.W(W), .E(E), .N(NB)) u1 (
    .clk(clk), .rstN(rstN), .start(start), .busy(busyB), .done(doneB), .rdAddr(raB),
    .xRdata(xdB), .yRdata(ydB), .mRdata(mdB), .resRdata(rdB),
    .resWe(weB), .resWaddr(waB), .resWdata(wdB)
  );

  always @(posedge clk) begin
    xdA <= xMem[raA]; ydA <= yMem[raA]; mdA <= mMem[raA]; rdA <= resA[raA];
    xdB <= xMem[raB]; ydB <= yMem[raB]; mdB <= mMem[raB]; rdB <= resB[raB];
    if (weA) resA[waA] <= wdA;
    if (weB) resB[waB] <= wdB;
  end

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic logic [K+1:0] montRef(input logic [K-1:0] xv, yv, mv);
    logic [K+1:0] s = '0;
    for (int i = 0; i < K; i++) begin
      if (xv[i]) s = s + {2'b00, yv};
      if (s[0]) s = s + {2'b00, mv};
      s = s >> 1;
    end
    return s;
  endfunction

  function automatic int latency(input int n, input bit sub);
    return E + (K / n) * (2 * n + E + 1) + E + 3 + (sub ? E + 1 : 0);
  endfunction

  task automatic runOp(input logic [K-1:0] xv, yv, mv, input bit poke, input string tag);
    logic [K+1:0] s;
    logic [K-1:0] expv, gotA, gotB;
    bit sub;
    int latA, latB, maxL;
    string msgA, msgB;
    s    = montRef(xv, yv, mv);
    sub  = (s >= {2'b00, mv});
    expv = sub ? K'(s - {2'b00, mv}) : K'(s);
    latA = latency(NA, sub);
    latB = latency(NB, sub);
    maxL = (latA > latB) ? latA : latB;
    for (int j = 0; j < E; j++) begin
      xMem[j] = xv[j*W +: W]; yMem[j] = yv[j*W +: W]; mMem[j] = mv[j*W +: W];
      resA[j] = 16'hA5C3; resB[j] = 16'h3CA5;
    end
    msgA = ""; msgB = "";
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < maxL + 2; c++) begin
      if (poke && c == 5) start = 1'b1;   // R7: extra start while busy
      if (poke && c == 6) start = 1'b0;
      if (msgA == "" && (busyA !== (c < latA) || doneA !== (c == latA - 1) || (weA && !busyA)))
        msgA = $sformatf("cycle %0d busy=%b done=%b we=%b", c, busyA, doneA, weA);
      if (msgB == "" && (busyB !== (c < latB) || doneB !== (c == latB - 1) || (weB && !busyB)))
        msgB = $sformatf("cycle %0d busy=%b done=%b we=%b", c, busyB, doneB, weB);
      @(negedge clk);
    end
    for (int j = 0; j < E; j++) begin
      gotA[j*W +: W] = resA[j];
      gotB[j*W +: W] = resB[j];
    end
    check(gotA == expv, {"R2 R3 R7 result N=4 ", tag}, $sformatf("%h", gotA), $sformatf("%h", expv));
    check(gotB == expv, {"R6 R7 result N=2 ", tag}, $sformatf("%h", gotB), $sformatf("%h", expv));
    check(msgA == "", {"R4 R5 R8 trace N=4 ", tag}, msgA, $sformatf("busy for %0d cycles", latA));
    check(msgB == "", {"R4 R5 R8 trace N=2 ", tag}, msgB, $sformatf("busy for %0d cycles", latB));
  endtask

  function automatic logic [K-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [K-1:0] m, xv, yv;
    for (int j = 0; j < E; j++) begin
      xMem[j] = '0; yMem[j] = '0; mMem[j] = '0; resA[j] = '0; resB[j] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busyA && !doneA && !weA && !busyB && !doneB && !weB, "R1 reset outputs",
          $sformatf("%b%b%b %b%b%b", busyA, doneA, weA, busyB, doneB, weB), "000 000");

    m = rnd64() | 64'h8000_0000_0000_0001;
    runOp('0, rnd64() % m, m, 1'b0, "R3 zero multiplier");
    m = {K{1'b1}};
    runOp(64'd1, 64'd1, m, 1'b0, "all-ones modulus");
    m = rnd64() | 64'd1;
    runOp(m - 1, m - 1, m, 1'b0, "operands M-1");
    m = rnd64() | 64'd1;
    runOp(rnd64() % m, rnd64() % m, m, 1'b1, "R7 start while busy");
    for (int t = 0; t < 8; t++) begin
      m = rnd64() | 64'd1;
      if (t % 2 == 1) m = m >> (8 * t);
      m = m | 64'd1;
      if (m < 3) m = 64'd3;
      xv = rnd64() % m;
      yv = rnd64() % m;
      runOp(xv, yv, m, 1'b0, $sformatf("random %0d", t));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400us;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule